// File: doc/BRIEF.md
# Transmitter Power-Mode Controller

This block sequences the power states of a serial display transmitter. It runs from a free-running reference clock. It watches three inputs: the transmitter enable pin, the incoming pixel clock and the lock indication of the clock multiplier. From these it decides which parts of the transmitter are powered and driving. There are four states. In Shutdown everything is off. In Standby only the clock-activity monitor runs. In Acquire the multiplier is powered and searching for lock. In Transmit the serializer loads frames and the outputs drive.

The enable pin passes through a glitch filter. A level change counts only after it has persisted for a programmable number of reference cycles. The one exception is power-up, when the filter takes the pin level directly. Pixel-clock activity is measured by counting pixel-clock edges over a fixed window of reference cycles. The edges reach the reference domain through a toggle synchronizer. The decision to start and the decision to stop use two separate thresholds, so the block has hysteresis. If lock does not arrive within a programmable timeout, the controller falls back to Standby, raises a sticky flag and tries again. When Transmit is entered, the output drivers turn on in a fixed order: serializer load first, then the clock lane, then the data lanes.

Top module: `txpm_ctrl`

## Requirements
- R1: The filtered enable changes only after the synchronized pin has held the opposite level for EN_FILT_CYC consecutive reference cycles. A pulse of either polarity that is shorter than this has no effect on `pwr_state`.
- R2: After reset is released, the filter adopts the pin level without the qualification delay. With the pin high, `pwr_state` leaves Shutdown within 10 reference cycles of reset release.
- R3: A filtered-low enable puts the block in Shutdown (`pwr_state` = 0) on the next cycle, from any state. In Shutdown, `pll_en`, `mon_en`, `ser_en`, `clk_oe` and `data_oe` are all 0.
- R4: Standby (`pwr_state` = 1) drives only `mon_en` high. Standby moves to Acquire (`pwr_state` = 2) at the end of a window whose pixel-edge count is at least HI_EDGES. In Acquire, `pll_en` and `mon_en` are 1 and all drive enables are 0.
- R5: Transmit (`pwr_state` = 3) is entered only from Acquire, on the cycle after `pll_lock` is seen high. `ser_en` rises on entry, `clk_oe` rises one cycle later and `data_oe` rises two cycles later.
- R6: A window count from LO_EDGES to HI_EDGES-1 leaves the activity decision unchanged. A running Transmit state stays in Transmit, and a Standby state stays in Standby.
- R7: A window count below LO_EDGES, such as a stopped pixel clock, returns Acquire or Transmit to Standby. In Standby, `pll_en` is 0 and `mon_en` is 1.
- R8: After LOCK_TO_CYC cycles in Acquire without lock, the block returns to Standby and sets `lock_to`. The flag stays set until reset. Acquire is retried at the next window that reports activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_pin | input | 1 | Raw transmitter enable pin |
| pix_clk | input | 1 | Incoming pixel clock |
| pll_lock | input | 1 | Lock indication from the clock multiplier |
| pwr_state | output | 2 | Current state: 0 Shutdown, 1 Standby, 2 Acquire, 3 Transmit |
| pll_en | output | 1 | Clock multiplier enable |
| mon_en | output | 1 | Pixel-clock activity monitor enable |
| ser_en | output | 1 | Serializer enable / frame load |
| clk_oe | output | 1 | Clock lane drive enable |
| data_oe | output | 1 | Data lane drive enable |
| lock_to | output | 1 | Sticky lock-timeout flag |

## Verification
The assertions assume that the pixel clock runs at less than half the reference rate. Above that, the toggle synchronizer would merge edges and the counts would be meaningless. They also assume that `pll_lock` is a clean level in the reference domain. The stimulus uses pixel periods of 40 ns and 120 ns against a 5 ns reference. It changes `pll_lock` only from the main sequence, well away from state changes. The 120 ns period is chosen so that every window count lands strictly inside the hysteresis band.

// File: rtl/txpm_pkg.sv
package txpm_pkg;

  typedef enum logic [1:0] {
    PM_SHUT = 2'd0,
    PM_STBY = 2'd1,
    PM_ACQ  = 2'd2,
    PM_XMIT = 2'd3
  } pm_state_e;

  localparam int unsigned XMIT_PH_W = 2;

endpackage

// File: rtl/txpm_en_filter.sv
module txpm_en_filter #(
  parameter int unsigned FILT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic en_q
);
  localparam int unsigned CW   = $clog2(FILT_CYC + 1);
  localparam int unsigned LAST = FILT_CYC - 1;

  logic          s1, s2;
  logic [1:0]    boot_cnt, boot_cnt_n;
  logic          boot_done;
  logic          en_n;
  logic [CW-1:0] cnt, cnt_n;

  assign boot_done = (boot_cnt == 2'd3);

  always_comb begin
    boot_cnt_n = boot_cnt;
    en_n       = en_q;
    cnt_n      = '0;
    if (!boot_done) begin
      boot_cnt_n = boot_cnt + 2'd1;
      en_n       = s2;
    end else if (s2 != en_q) begin
      if (cnt == CW'(LAST)) begin
        en_n  = s2;
        cnt_n = '0;
      end else begin
        cnt_n = cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b0;
      s2       <= 1'b0;
      boot_cnt <= 2'd0;
      en_q     <= 1'b0;
      cnt      <= '0;
    end else begin
      s1       <= pin_raw;
      s2       <= s1;
      boot_cnt <= boot_cnt_n;
      en_q     <= en_n;
      cnt      <= cnt_n;
    end
  end

  // R1: the qualification counter never runs past its limit
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(FILT_CYC));

  // R1: after power-up, a level change needs an uninterrupted run of differing samples
  p_flip_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && $past(boot_done) && !$stable(en_q)) |-> ($past(cnt) == CW'(LAST)));

endmodule

// File: rtl/txpm_act_mon.sv
module txpm_act_mon #(
  parameter int unsigned WIN_CYC  = 1000,
  parameter int unsigned LO_EDGES = 5,
  parameter int unsigned HI_EDGES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_clk,
  input  logic mon_en,
  output logic act,
  output logic eval
);
  localparam int unsigned WW = $clog2(WIN_CYC);
  localparam int unsigned EW = $clog2(WIN_CYC + 1) + 1;

  logic          tgl;
  logic          t1, t2, t3;
  logic          edge_p;
  logic [WW-1:0] wcnt, wcnt_n;
  logic [EW-1:0] ecnt, ecnt_n, total;
  logic          act_n, eval_n;

  // pixel-clock domain: one toggle per rising edge
  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  assign edge_p = t2 ^ t3;
  assign total  = ecnt + EW'(edge_p);

  always_comb begin
    wcnt_n = wcnt;
    ecnt_n = ecnt;
    act_n  = act;
    eval_n = 1'b0;
    if (!mon_en) begin
      wcnt_n = '0;
      ecnt_n = '0;
      act_n  = 1'b0;
    end else if (wcnt == WW'(WIN_CYC - 1)) begin
      wcnt_n = '0;
      ecnt_n = '0;
      eval_n = 1'b1;
      if (total < EW'(LO_EDGES))       act_n = 1'b0;
      else if (total >= EW'(HI_EDGES)) act_n = 1'b1;
    end else begin
      wcnt_n = wcnt + WW'(1);
      ecnt_n = total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1   <= 1'b0;
      t2   <= 1'b0;
      t3   <= 1'b0;
      wcnt <= '0;
      ecnt <= '0;
      act  <= 1'b0;
      eval <= 1'b0;
    end else begin
      t1   <= tgl;
      t2   <= t1;
      t3   <= t2;
      wcnt <= wcnt_n;
      ecnt <= ecnt_n;
      act  <= act_n;
      eval <= eval_n;
    end
  end

  // R6: while monitoring, the decision moves only together with a window report
  p_act_on_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && $past(mon_en) && !$stable(act)) |-> eval);

  // R4: a window report never comes two cycles in a row
  p_eval_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> !eval);

endmodule

// File: rtl/txpm_fsm.sv
module txpm_fsm
  import txpm_pkg::*;
#(
  parameter int unsigned LOCK_TO_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_q,
  input  logic       act,
  input  logic       eval,
  input  logic       pll_lock,
  output pm_state_e  state,
  output logic       pll_en,
  output logic       mon_en,
  output logic       ser_en,
  output logic       clk_oe,
  output logic       data_oe,
  output logic       lock_to
);
  localparam int unsigned TW = $clog2(LOCK_TO_CYC + 1);

  pm_state_e            st_n;
  logic [TW-1:0]        tcnt, tcnt_n;
  logic [XMIT_PH_W-1:0] ph, ph_n;
  logic                 to_hit;
  logic                 lock_to_n;

  always_comb begin
    st_n   = state;
    to_hit = 1'b0;
    if (!en_q) begin
      st_n = PM_SHUT;
    end else begin
      unique case (state)
        PM_SHUT: st_n = PM_STBY;
        PM_STBY: if (eval && act) st_n = PM_ACQ;
        PM_ACQ: begin
          if (!act)          st_n = PM_STBY;
          else if (pll_lock) st_n = PM_XMIT;
          else if (tcnt == TW'(LOCK_TO_CYC - 1)) begin
            st_n   = PM_STBY;
            to_hit = 1'b1;
          end
        end
        PM_XMIT: if (!act) st_n = PM_STBY;
        default: st_n = PM_SHUT;
      endcase
    end
  end

  always_comb begin
    tcnt_n    = (state == PM_ACQ && st_n == PM_ACQ) ? tcnt + TW'(1) : '0;
    ph_n      = '0;
    if (state == PM_XMIT && st_n == PM_XMIT)
      ph_n = (ph == 2'd2) ? ph : ph + 2'd1;
    lock_to_n = lock_to | to_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PM_SHUT;
      tcnt    <= '0;
      ph      <= '0;
      lock_to <= 1'b0;
    end else begin
      state   <= st_n;
      tcnt    <= tcnt_n;
      ph      <= ph_n;
      lock_to <= lock_to_n;
    end
  end

  assign mon_en  = (state != PM_SHUT);
  assign pll_en  = (state == PM_ACQ) || (state == PM_XMIT);
  assign ser_en  = (state == PM_XMIT);
  assign clk_oe  = ser_en && (ph != 2'd0);
  assign data_oe = ser_en && (ph == 2'd2);

  // R3: a deasserted filtered enable forces Shutdown next cycle
  p_disable_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (state == PM_SHUT));

  // R5: Transmit is entered only from Acquire with lock present
  p_xmit_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_XMIT && $past(state) != PM_XMIT) |->
      ($past(state) == PM_ACQ && $past(pll_lock)));

  // R5: data lanes never start before the clock lane has driven a cycle
  p_lanes_after_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> (clk_oe && $past(clk_oe)));

  // R4: Acquire is entered only from Standby after an active window
  p_acq_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_ACQ && $past(state) == PM_STBY) |-> ($past(eval) && $past(act)));

  // R7: losing activity while powered returns to Standby
  p_loss_to_stby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PM_ACQ || state == PM_XMIT) && en_q && !act) |=> (state == PM_STBY));

  // R8: the timeout flag never clears outside reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_to) |-> lock_to);

endmodule

// File: rtl/txpm_ctrl.sv
module txpm_ctrl
  import txpm_pkg::*;
#(
  parameter int unsigned EN_FILT_CYC = 1000,
  parameter int unsigned WIN_CYC     = 1000,
  parameter int unsigned LO_EDGES    = 5,
  parameter int unsigned HI_EDGES    = 30,
  parameter int unsigned LOCK_TO_CYC = 200000
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       pix_clk,
  input  logic       pll_lock,
  output logic [1:0] pwr_state,
  output logic       pll_en,
  output logic       mon_en,
  output logic       ser_en,
  output logic       clk_oe,
  output logic       data_oe,
  output logic       lock_to
);
  logic      rs1, rst_ni;
  logic      en_q;
  logic      act, eval;
  pm_state_e state;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rs1    <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rs1    <= 1'b1;
      rst_ni <= rs1;
    end
  end

  txpm_en_filter #(.FILT_CYC(EN_FILT_CYC)) u_filt (
    .clk     (clk_ref),
    .rst_n   (rst_ni),
    .pin_raw (en_pin),
    .en_q    (en_q)
  );

  txpm_act_mon #(
    .WIN_CYC  (WIN_CYC),
    .LO_EDGES (LO_EDGES),
    .HI_EDGES (HI_EDGES)
  ) u_mon (
    .clk     (clk_ref),
    .rst_n   (rst_ni),
    .pix_clk (pix_clk),
    .mon_en  (mon_en),
    .act     (act),
    .eval    (eval)
  );

  txpm_fsm #(.LOCK_TO_CYC(LOCK_TO_CYC)) u_fsm (
    .clk      (clk_ref),
    .rst_n    (rst_ni),
    .en_q     (en_q),
    .act      (act),
    .eval     (eval),
    .pll_lock (pll_lock),
    .state    (state),
    .pll_en   (pll_en),
    .mon_en   (mon_en),
    .ser_en   (ser_en),
    .clk_oe   (clk_oe),
    .data_oe  (data_oe),
    .lock_to  (lock_to)
  );

  assign pwr_state = state;

endmodule

// File: tb/txpm_ctrl_bench.sv
`timescale 1ns/1ps
module txpm_ctrl_bench;
  localparam int FILT = 20;
  localparam int WIN  = 64;
  localparam int LTO  = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_pin = 1'b0;
  logic       pix_clk = 1'b0;
  logic       pll_lock = 1'b0;
  logic [1:0] pwr_state;
  logic       pll_en, mon_en, ser_en, clk_oe, data_oe, lock_to;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  pix_run = 1'b0;
  real pix_half = 20.0;

  txpm_ctrl #(
    .EN_FILT_CYC (FILT),
    .WIN_CYC     (WIN),
    .LO_EDGES    (2),
    .HI_EDGES    (4),
    .LOCK_TO_CYC (LTO)
  ) u_txpm_ctrl (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .en_pin    (en_pin),
    .pix_clk   (pix_clk),
    .pll_lock  (pll_lock),
    .pwr_state (pwr_state),
    .pll_en    (pll_en),
    .mon_en    (mon_en),
    .ser_en    (ser_en),
    .clk_oe    (clk_oe),
    .data_oe   (data_oe),
    .lock_to   (lock_to)
  );

  always #2.5 clk = ~clk;

  always begin
    if (pix_run) #(pix_half) pix_clk = ~pix_clk;
    else         #5;
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mode(input int m, input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (pwr_state == 2'(m)) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // per-cycle reference model of the output enables and legal moves
  int  xage = 0;
  int  prev_m = 0;
  bit  prev_lt = 1'b0;
  bit  model_on = 1'b0;

  always @(negedge clk) begin
    if (!rst_n || !model_on) begin
      xage = 0; prev_m = 0; prev_lt = 1'b0;
    end else begin
      int m;
      bit legal;
      m = int'(pwr_state);
      check("R3", int'(mon_en), int'(m != 0));
      check("R4", int'(pll_en), int'(m >= 2));
      check("R5", int'(ser_en), int'(m == 3));
      check("R5", int'(clk_oe), int'(m == 3 && xage >= 1));
      check("R5", int'(data_oe), int'(m == 3 && xage >= 2));
      case (prev_m)
        0: legal = (m <= 1);
        1: legal = (m <= 2);
        2: legal = 1'b1;
        default: legal = (m != 2);
      endcase
      check("R5", int'(legal), 1);
      if (prev_lt) check("R8", int'(lock_to), 1);
      xage    = (m == 3) ? xage + 1 : 0;
      prev_m  = m;
      prev_lt = lock_to;
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // A: reset state, pin low (R3)
    cyc(4);
    check("R3", int'(pwr_state), 0);
    check("R3", int'(pll_en | mon_en | ser_en | clk_oe | data_oe | lock_to), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    cyc(40);
    check("R3", int'(pwr_state), 0);

    // B: short high pulse on the pin is ignored (R1)
    en_pin = 1'b1; cyc(FILT / 2); en_pin = 1'b0;
    cyc(3 * FILT);
    check("R1", int'(pwr_state), 0);

    // C: long high qualifies after the filter delay (R1)
    en_pin = 1'b1;
    cyc(15);
    check("R1", int'(pwr_state), 0);
    cyc(15);
    check("R1", int'(pwr_state), 1);
    check("R4", int'(mon_en), 1);
    check("R4", int'(pll_en), 0);

    // D: active pixel clock -> Acquire (R4)
    pix_half = 20.0; pix_run = 1'b1;
    wait_mode(2, 4 * WIN);
    check("R4", int'(pwr_state), 2);
    check("R4", int'(pll_en), 1);
    check("R4", int'(clk_oe | data_oe | ser_en), 0);

    // E: lock -> Transmit with ordered turn-on (R5)
    cyc(10);
    pll_lock = 1'b1;
    wait_mode(3, 10);
    check("R5", int'(pwr_state), 3);
    check("R5", int'({ser_en, clk_oe, data_oe}), 3'b100);
    cyc(1);
    check("R5", int'({ser_en, clk_oe, data_oe}), 3'b110);
    cyc(1);
    check("R5", int'({ser_en, clk_oe, data_oe}), 3'b111);

    // F: short low glitch on the pin keeps Transmit (R1)
    en_pin = 1'b0; cyc(FILT / 2); en_pin = 1'b1;
    cyc(3 * FILT);
    check("R1", int'(pwr_state), 3);

    // G: pixel rate inside the hysteresis band keeps Transmit (R6)
    pix_half = 60.0;
    cyc(12 * WIN);
    check("R6", int'(pwr_state), 3);

    // H: pixel clock stops -> Standby (R7)
    pll_lock = 1'b0;
    pix_run = 1'b0;
    wait_mode(1, 4 * WIN);
    check("R7", int'(pwr_state), 1);
    check("R7", int'(pll_en), 0);
    check("R7", int'(mon_en), 1);

    // I: band rate from Standby does not start Acquire (R6)
    pix_half = 60.0; pix_run = 1'b1;
    cyc(12 * WIN);
    check("R6", int'(pwr_state), 1);

    // J: no lock -> timeout, flag, retry (R8)
    pix_half = 20.0;
    wait_mode(2, 4 * WIN);
    check("R8", int'(pwr_state), 2);
    cyc(LTO - 20);
    check("R8", int'(pwr_state), 2);
    check("R8", int'(lock_to), 0);
    wait_mode(1, 40);
    check("R8", int'(pwr_state), 1);
    check("R8", int'(lock_to), 1);
    wait_mode(2, 2 * WIN);
    check("R8", int'(pwr_state), 2);

    // K: lock on retry, flag remains (R8)
    pll_lock = 1'b1;
    wait_mode(3, 10);
    check("R5", int'(pwr_state), 3);
    check("R8", int'(lock_to), 1);

    // L: long low pin -> Shutdown from Transmit (R3)
    en_pin = 1'b0;
    wait_mode(0, FILT + 10);
    check("R3", int'(pwr_state), 0);
    cyc(1);
    check("R3", int'(pll_en | mon_en | ser_en | clk_oe | data_oe), 0);
    check("R8", int'(lock_to), 1);

    // M: power-up with pin high bypasses the filter (R2)
    model_on = 1'b0;
    pll_lock = 1'b0;
    pix_run = 1'b0;
    en_pin = 1'b1;
    rst_n = 1'b0;
    cyc(3);
    check("R8", int'(lock_to), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    cyc(10);
    check("R2", int'(pwr_state), 1);
    check("R2", int'(mon_en), 1);

    cyc(5);
    finish_run();
  end

endmodule